// File: doc/BRIEF.md
# Toggle-Flagged Bus Clock-Domain Crossing

This block carries a wide data word from one clock domain to another that runs on an unrelated clock. In the source domain, a completion strobe stores the word in a holding register. On the same edge it inverts a one-bit flag, so each new word shows up as a change of the flag, in either direction, and not as a level.

Only the flag crosses the boundary, through a chain of destination-clock flip-flops. When the last two flops of that chain disagree, the destination register copies the holding register straight from the source domain. Because the flag needs several destination cycles to get through the chain, the held bus has long settled by the time it is sampled. A one-cycle pulse marks each captured word.

The user must space strobes at least twelve source edges apart. The block is meant for either direction between a 36 MHz and a 100 MHz clock. A single asynchronous reset clears both domains.

Top module: `tgl_bus_xfer`

## Requirements
- R1: While `arst_n` is low, `dst_word` is zero and `dst_new` is low. After reset is released with no strobe, `dst_new` stays low and `dst_word` stays zero.
- R2: The word delivered for a strobe is the value `src_word` held on the source edge where `src_done` was high. Values on `src_word` at other edges have no effect.
- R3: Every strobe produces exactly one delivery, in strobe order, with no duplicates and no capture without a strobe. This holds whether the internal flag changes from 0 to 1 or from 1 to 0.
- R4: `dst_new` is high for exactly one destination cycle per word. That cycle is the same one in which `dst_word` first shows the new word.
- R5: `dst_word` does not change in any destination cycle where `dst_new` is low.
- R6: With the default `SYNC_STAGES` = 3, `dst_new` rises on the third or fourth rising `dst_clk` edge after the source edge that took the strobe.
- R7: R2 to R6 hold with a 36 MHz source and 100 MHz destination, and with a 100 MHz source and 36 MHz destination, when strobes are 12 or more source edges apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| arst_n | input | 1 | Asynchronous reset for both domains, active low |
| src_done | input | 1 | Completion strobe: load `src_word` on this source edge |
| src_word | input | DATA_W | Word to transfer |
| dst_clk | input | 1 | Destination domain clock |
| dst_word | output | DATA_W | Most recently captured word |
| dst_new | output | 1 | One-cycle pulse marking a new `dst_word` |

## Verification
A flag that fails to invert, or that inverts twice, shows at the ports as a missing or extra `dst_new` pulse. That symptom appears within four destination cycles of the strobe, and the word order then goes out of step. A detector tapped on the wrong synchronizer stage moves the pulse out of its third-to-fourth-edge window on the very first word. A holding register that follows the input between strobes delivers a value that `src_word` carried after the strobe edge. A capture register that loads outside the pulse shows up as a `dst_word` change in a cycle where `dst_new` is low.

// File: rtl/tgl_bus_xfer_pkg.sv
`timescale 1ns/1ps
package tgl_bus_xfer_pkg;
   localparam int unsigned SYNC_MIN      = 2;
   localparam int unsigned SYNC_DEFAULT  = 3;
   localparam int unsigned WIDTH_DEFAULT = 32;

   // a word is announced by any change of the flag
   function automatic logic flag_changed(input logic newer, input logic older);
      return newer ^ older;
   endfunction
endpackage

// File: rtl/tgl_src_hold.sv
`timescale 1ns/1ps
module tgl_src_hold #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] hold,
   output logic              flag
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hold <= '0;
         flag <= 1'b0;
      end else if (load) begin
         hold <= din;
         flag <= ~flag;
      end
   end
endmodule

// File: rtl/tgl_flag_sync.sv
`timescale 1ns/1ps
module tgl_flag_sync #(
   parameter int unsigned STAGES = 3
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic tap_last,
   output logic tap_prev
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) chain[0] <= 1'b0;
               else         chain[0] <= d;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) chain[i] <= 1'b0;
               else         chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign tap_last = chain[STAGES-1];
   assign tap_prev = chain[STAGES-2];
endmodule

// File: rtl/tgl_dst_capture.sv
`timescale 1ns/1ps
module tgl_dst_capture
   import tgl_bus_xfer_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              tap_last,
   input  logic              tap_prev,
   input  logic [DATA_W-1:0] bus,
   output logic [DATA_W-1:0] word,
   output logic              strobe
);
   logic fire;
   assign fire = flag_changed(tap_prev, tap_last);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         word   <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= fire;
         if (fire) word <= bus;
      end
   end
endmodule

// File: rtl/tgl_bus_xfer.sv
`timescale 1ns/1ps
module tgl_bus_xfer
   import tgl_bus_xfer_pkg::*;
#(
   parameter int unsigned DATA_W      = WIDTH_DEFAULT,
   parameter int unsigned SYNC_STAGES = SYNC_DEFAULT
) (
   input  logic              src_clk,
   input  logic              arst_n,
   input  logic              src_done,
   input  logic [DATA_W-1:0] src_word,
   input  logic              dst_clk,
   output logic [DATA_W-1:0] dst_word,
   output logic              dst_new
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("tgl_bus_xfer: DATA_W must be at least 1");
      end
      if (SYNC_STAGES < SYNC_MIN) begin : g_bad_depth
         $error("tgl_bus_xfer: SYNC_STAGES below minimum");
      end
   endgenerate

   logic [DATA_W-1:0] hold_q;
   logic              flag_q;
   logic              tap_last;
   logic              tap_prev;

   tgl_src_hold #(.DATA_W(DATA_W)) u_src (
      .clk(src_clk), .arst_n(arst_n), .load(src_done), .din(src_word),
      .hold(hold_q), .flag(flag_q)
   );

   tgl_flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(dst_clk), .arst_n(arst_n), .d(flag_q),
      .tap_last(tap_last), .tap_prev(tap_prev)
   );

   tgl_dst_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(dst_clk), .arst_n(arst_n), .tap_last(tap_last), .tap_prev(tap_prev),
      .bus(hold_q), .word(dst_word), .strobe(dst_new)
   );
endmodule

// File: rtl/tgl_bus_xfer_chk.sv
`timescale 1ns/1ps
module tgl_bus_xfer_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              src_clk,
   input logic              dst_clk,
   input logic              arst_n,
   input logic              src_done,
   input logic [DATA_W-1:0] src_word,
   input logic [DATA_W-1:0] hold_q,
   input logic              flag_q,
   input logic [DATA_W-1:0] dst_word,
   input logic              dst_new
);
   AST_HOLD_TAKES_WORD: assert property (@(posedge src_clk) disable iff (!arst_n)
      src_done |=> hold_q == $past(src_word)) else $error("AST_HOLD_TAKES_WORD"); // R2

   AST_HOLD_KEEPS: assert property (@(posedge src_clk) disable iff (!arst_n)
      !src_done |=> $stable(hold_q)) else $error("AST_HOLD_KEEPS"); // R2

   AST_FLAG_FLIPS: assert property (@(posedge src_clk) disable iff (!arst_n)
      src_done |=> flag_q != $past(flag_q)) else $error("AST_FLAG_FLIPS"); // R3

   AST_FLAG_QUIET: assert property (@(posedge src_clk) disable iff (!arst_n)
      !src_done |=> $stable(flag_q)) else $error("AST_FLAG_QUIET"); // R3

   AST_PULSE_SINGLE: assert property (@(posedge dst_clk) disable iff (!arst_n)
      dst_new |=> !dst_new) else $error("AST_PULSE_SINGLE"); // R4

   AST_CAPTURE_MATCH: assert property (@(posedge dst_clk) disable iff (!arst_n)
      dst_new |-> dst_word == hold_q) else $error("AST_CAPTURE_MATCH"); // R4

   AST_WORD_STEADY: assert property (@(posedge dst_clk) disable iff (!arst_n)
      !dst_new |-> $stable(dst_word)) else $error("AST_WORD_STEADY"); // R5
endmodule

bind tgl_bus_xfer tgl_bus_xfer_chk #(.DATA_W(DATA_W)) u_chk (
   .src_clk(src_clk), .dst_clk(dst_clk), .arst_n(arst_n), .src_done(src_done),
   .src_word(src_word), .hold_q(hold_q), .flag_q(flag_q),
   .dst_word(dst_word), .dst_new(dst_new)
);

// File: tb/tgl_bus_xfer_test.sv
`timescale 1ns/1ps
module tgl_bus_xfer_test;
   localparam int unsigned W = 32;

   logic         src_clk = 1'b0;
   logic         dst_clk = 1'b0;
   logic         arst_n  = 1'b0;
   logic         src_done = 1'b0;
   logic [W-1:0] src_word = '0;
   logic [W-1:0] dst_word;
   logic         dst_new;

   realtime half_s = 13.9;
   realtime half_d = 5.0;

   int n_chk  = 0;
   int n_fail = 0;
   logic mon_en = 1'b0;
   logic prev_new = 1'b0;
   logic [W-1:0] last_word = '0;
   logic [W-1:0] exp_q[$];
   realtime      t_q[$];

   tgl_bus_xfer #(.DATA_W(W), .SYNC_STAGES(3)) uut (
      .src_clk(src_clk), .arst_n(arst_n), .src_done(src_done),
      .src_word(src_word), .dst_clk(dst_clk), .dst_word(dst_word), .dst_new(dst_new)
   );

   always begin #(half_s); src_clk = ~src_clk; end
   initial begin #1.3; forever begin #(half_d); dst_clk = ~dst_clk; end end

   // stimulus vectors: {spacing in source edges, word}; expected delivery is the word itself
   localparam logic [39:0] VEC [16] = '{
      {8'd12, 32'hDEAD_BEEF}, {8'd12, 32'h0000_0001}, {8'd12, 32'hFFFF_FFFF},
      {8'd12, 32'h0000_0000}, {8'd13, 32'hA5A5_A5A5}, {8'd20, 32'h5A5A_5A5A},
      {8'd12, 32'h8000_0000}, {8'd15, 32'h1234_5678}, {8'd12, 32'h1234_5678},
      {8'd31, 32'h0F0F_F0F0}, {8'd12, 32'hCAFE_F00D}, {8'd17, 32'h7FFF_FFFF},
      {8'd12, 32'h0000_FFFF}, {8'd12, 32'hFFFF_0000}, {8'd40, 32'h2468_ACE0},
      {8'd12, 32'h1357_9BDF}
   };

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $realtime);
      end
   endtask

   task automatic send(input logic [W-1:0] w, input int spacing);
      @(negedge src_clk);
      src_done = 1'b1;
      src_word = w;
      @(posedge src_clk);
      exp_q.push_back(w);
      t_q.push_back($realtime);
      @(negedge src_clk);
      src_done = 1'b0;
      src_word = ~w ^ $urandom();   // R2: junk between strobes must not be captured
      repeat (spacing - 2) @(negedge src_clk);
   endtask

   // destination monitor, sampled at the falling edge
   always @(negedge dst_clk) begin
      if (arst_n && mon_en) begin
         if (dst_new) begin
            check(!prev_new, "R4 pulse longer than one cycle", {31'd0, prev_new}, '0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R3 capture without strobe", dst_word, '0);
            end else begin
               logic [W-1:0] e;
               realtime t0, dt, td;
               e  = exp_q.pop_front();
               t0 = t_q.pop_front();
               dt = $realtime - t0;
               td = 2.0 * half_d;
               check(dst_word == e, "R2/R3/R7 delivered word", dst_word, e);
               check(dt >= 2.4 * td && dt <= 3.6 * td, "R6 latency window",
                     W'(int'(dt * 10.0)), W'(int'(td * 30.0)));
            end
            last_word = dst_word;
         end else begin
            check(dst_word == last_word, "R5 word changed without pulse", dst_word, last_word);
         end
         prev_new = dst_new;
      end
   end

   task automatic do_reset();
      mon_en = 1'b0;
      arst_n = 1'b0;
      exp_q.delete();
      t_q.delete();
      #3;
      check(dst_word == '0, "R1 word in reset", dst_word, '0);
      check(dst_new == 1'b0, "R1 pulse in reset", {31'd0, dst_new}, '0);
      #50;
      last_word = '0;
      prev_new  = 1'b0;
      @(negedge src_clk);
      arst_n = 1'b1;
      mon_en = 1'b1;
   endtask

   task automatic run_phase();
      do_reset();
      repeat (10) @(negedge dst_clk);
      check(dst_word == '0 && !dst_new, "R1 idle after release", dst_word, '0);
      for (int i = 0; i < 16; i++) send(VEC[i][31:0], int'(VEC[i][39:32]));
      for (int i = 0; i < 24; i++) send($urandom(), int'($urandom_range(12, 45)));
      repeat (20) @(negedge dst_clk);
      check(exp_q.size() == 0, "R3 words lost", W'(exp_q.size()), '0);
      // reset with a word in flight: it must vanish, and nothing spurious follows
      send(32'hBAD0_0BAD, 2);
      do_reset();
      repeat (12) @(negedge dst_clk);
      check(dst_word == '0 && !dst_new, "R1 in-flight word dropped by reset", dst_word, '0);
      send(32'h600D_600D, 12);
      repeat (20) @(negedge dst_clk);
      check(dst_word == 32'h600D_600D, "R3 first word after reset", dst_word, 32'h600D_600D);
      check(exp_q.size() == 0, "R3 words lost after reset", W'(exp_q.size()), '0);
   endtask

   initial begin
      half_s = 13.9; half_d = 5.0;   // R7: 36 MHz source, 100 MHz destination
      run_phase();
      half_s = 5.0;  half_d = 13.9;  // R7: 100 MHz source, 36 MHz destination
      run_phase();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule